// File: doc/BRIEF.md
# Character-Row Raster Timing Generator

This block produces the timing skeleton of a character-organised raster display: horizontal and vertical sync pulses, a display-enable window, a 14-bit video memory address and the raster-line number inside the current character row. It does not fetch memory or draw pixels. It only tells a downstream video fetcher where it is in the frame and which word of video memory belongs to the current character cell.

Three nested counters do the work: the character position inside a line, the raster line inside a character row, and the character row inside a frame. They advance only on cycles where the one-per-character clock enable is high. After the last character row, an optional tail of extra raster lines runs before the frame wraps. Eleven 8-bit timing values are written through a simple parallel load port. A mode input makes the address generator reload the start address on every raster line of row zero instead of once per frame.

Top module: `crt_raster_timer`

## Requirements
- R1: A synchronous active-high reset clears all counters, the row base, MA and RA to zero and clears every timing value to zero. On the first cycle after reset HSYNC, VSYNC and DISPEN are low.
- R2: When the load strobe is high, the 8-bit data is stored at the selected index. The indices are: 0 line total, 1 displayed characters, 2 HSYNC character, 3 sync widths (bits 3:0 HSYNC in characters, bits 7:4 VSYNC in lines), 4 last row, 5 extra lines (bits 4:0), 6 displayed rows, 7 VSYNC row, 8 last raster line of a row (bits 4:0), 9 start address bits 13:8 (from data bits 5:0), 10 start address bits 7:0. Row values use bits 6:0. Indices 11 to 15 change nothing.
- R3: The counters, syncs and MA change only on clock edges where the character enable is high. A raster line lasts line total + 1 character periods.
- R4: DISPEN is high when the character position is below the displayed-characters value, the row is below the displayed-rows value, and the extra-line tail is not running.
- R5: HSYNC rises in the character period whose position equals the HSYNC character and stays high for the HSYNC width in character periods, continuing across a line end if needed. A width of 0 produces no HSYNC.
- R6: VSYNC rises when line 0 of the VSYNC row is entered and stays high for the VSYNC width in raster lines. A width of 0 means 16 lines.
- R7: RA counts from 0 to the last-line value within each row. Rows count from 0 to the last-row value. Then the extra-line count of additional lines follows, with RA counting from 0 again. After that the frame wraps to row 0, line 0.
- R8: MA increments by one for each character. At a line end it returns to the current row base. At the end of a row's last line the row base advances by the displayed-characters value, modulo 2^14.
- R9: At a frame wrap, both MA and the row base are loaded with the 14-bit start address.
- R10: When the row-zero reload input is high, MA and the row base are loaded with the start address at the start of every raster line of row 0.
- R11: With line total 63, last row 38, last line 7 and no extra lines, HSYNC rises every 64 character periods and VSYNC every 19968 character periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| char_en | input | 1 | One-cycle pulse per character period |
| cfg_we | input | 1 | Timing value load strobe |
| cfg_sel | input | 4 | Index of the timing value being loaded |
| cfg_wdata | input | 8 | Timing value data |
| reload_row0 | input | 1 | Reload the start address on every line of row 0 |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| dispen | output | 1 | Display enable |
| ma | output | 14 | Video memory address |
| ra | output | 5 | Raster line within the character row |

## Verification
The assertions assume that timing values are loaded only on cycles without a character enable. Several properties therefore discount cycles with a load, and the address checks hold only if the start address does not change in the same cycle as a wrap. The stimulus keeps to this rule: every load is issued with the enable low, and the block is reset before each new configuration, so no counter is ever caught beyond a freshly lowered total. Between loads, the enable pattern varies between every cycle and two cycles out of three.

// File: rtl/crt_raster_pkg.sv
`timescale 1ns/1ps
package crt_raster_pkg;
    localparam int CHAR_W = 8;   // character position and horizontal values
    localparam int ROW_W  = 7;   // character row values
    localparam int LINE_W = 5;   // raster line values
    localparam int ADDR_W = 14;  // video memory address
    localparam int SYNC_W = 4;   // each sync width field
    localparam int SEL_W  = 4;
    localparam int DATA_W = 8;
    localparam int HI_W   = ADDR_W - DATA_W;

    localparam logic [SEL_W-1:0] SEL_LINE_TOTAL  = 4'd0;
    localparam logic [SEL_W-1:0] SEL_CHARS_SHOWN = 4'd1;
    localparam logic [SEL_W-1:0] SEL_HSYNC_AT    = 4'd2;
    localparam logic [SEL_W-1:0] SEL_WIDTHS      = 4'd3;
    localparam logic [SEL_W-1:0] SEL_LAST_ROW    = 4'd4;
    localparam logic [SEL_W-1:0] SEL_EXTRA_LINES = 4'd5;
    localparam logic [SEL_W-1:0] SEL_ROWS_SHOWN  = 4'd6;
    localparam logic [SEL_W-1:0] SEL_VSYNC_ROW   = 4'd7;
    localparam logic [SEL_W-1:0] SEL_LAST_LINE   = 4'd8;
    localparam logic [SEL_W-1:0] SEL_BASE_HI     = 4'd9;
    localparam logic [SEL_W-1:0] SEL_BASE_LO     = 4'd10;

    typedef struct packed {
        logic [CHAR_W-1:0] h_total;
        logic [CHAR_W-1:0] h_disp;
        logic [CHAR_W-1:0] hs_pos;
        logic [SYNC_W-1:0] vs_width;
        logic [SYNC_W-1:0] hs_width;
        logic [ROW_W-1:0]  v_total;
        logic [ROW_W-1:0]  v_disp;
        logic [ROW_W-1:0]  vs_pos;
        logic [LINE_W-1:0] v_adjust;
        logic [LINE_W-1:0] max_line;
        logic [ADDR_W-1:0] start_addr;
    } raster_cfg_t;
endpackage

// File: rtl/crt_cfg_regs.sv
`timescale 1ns/1ps
module crt_cfg_regs
    import crt_raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output raster_cfg_t       cfg
);
    raster_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (sel)
                SEL_LINE_TOTAL:  cfg_d.h_total  = wdata[CHAR_W-1:0];
                SEL_CHARS_SHOWN: cfg_d.h_disp   = wdata[CHAR_W-1:0];
                SEL_HSYNC_AT:    cfg_d.hs_pos   = wdata[CHAR_W-1:0];
                SEL_WIDTHS: begin
                    cfg_d.hs_width = wdata[SYNC_W-1:0];
                    cfg_d.vs_width = wdata[2*SYNC_W-1:SYNC_W];
                end
                SEL_LAST_ROW:    cfg_d.v_total  = wdata[ROW_W-1:0];
                SEL_EXTRA_LINES: cfg_d.v_adjust = wdata[LINE_W-1:0];
                SEL_ROWS_SHOWN:  cfg_d.v_disp   = wdata[ROW_W-1:0];
                SEL_VSYNC_ROW:   cfg_d.vs_pos   = wdata[ROW_W-1:0];
                SEL_LAST_LINE:   cfg_d.max_line = wdata[LINE_W-1:0];
                SEL_BASE_HI:     cfg_d.start_addr[ADDR_W-1:DATA_W] = wdata[HI_W-1:0];
                SEL_BASE_LO:     cfg_d.start_addr[DATA_W-1:0]      = wdata;
                default: ;  // unused indices are ignored
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/crt_hcount.sv
`timescale 1ns/1ps
module crt_hcount
    import crt_raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [CHAR_W-1:0] h_total,
    input  logic [CHAR_W-1:0] h_disp,
    input  logic [CHAR_W-1:0] hs_pos,
    input  logic [SYNC_W-1:0] hs_width,
    output logic              line_end,
    output logic              h_active,
    output logic              hsync
);
    typedef struct packed {
        logic [CHAR_W-1:0] pos;
        logic [SYNC_W-1:0] hs_left;  // sync periods still owed after this one
    } hstate_t;

    hstate_t st_d, st_q;
    logic    hs_start;

    always_comb begin
        // >= keeps a lowered total from letting the counter run to wrap
        line_end = (st_q.pos >= h_total);
        hs_start = (st_q.pos == hs_pos) && (hs_width != '0);
        hsync    = hs_start || (st_q.hs_left != '0);
        h_active = (st_q.pos < h_disp);

        st_d = st_q;
        if (tick) begin
            st_d.pos = line_end ? '0 : st_q.pos + 1'b1;
            if (hs_start)
                st_d.hs_left = hs_width - 1'b1;
            else if (st_q.hs_left != '0)
                st_d.hs_left = st_q.hs_left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/crt_vcount.sv
`timescale 1ns/1ps
module crt_vcount
    import crt_raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              line_end,
    input  logic [ROW_W-1:0]  v_total,
    input  logic [ROW_W-1:0]  v_disp,
    input  logic [ROW_W-1:0]  vs_pos,
    input  logic [LINE_W-1:0] v_adjust,
    input  logic [LINE_W-1:0] max_line,
    input  logic [SYNC_W-1:0] vs_width,
    output logic [LINE_W-1:0] ra,
    output logic              in_adj,
    output logic              v_active,
    output logic              vsync,
    output logic              frame_wrap,
    output logic              row_done,
    output logic              next_row0
);
    localparam int VS_CNT_W = SYNC_W + 1;
    localparam logic [VS_CNT_W-1:0] VS_FULL = VS_CNT_W'(1 << SYNC_W);

    typedef struct packed {
        logic [ROW_W-1:0]    row;
        logic [LINE_W-1:0]   line;
        logic                adj;
        logic [VS_CNT_W-1:0] vs_left;
    } vstate_t;

    vstate_t st_d, st_q, nxt;
    logic    last_row;
    logic    adj_over;
    logic    vs_enter;
    logic [VS_CNT_W-1:0] vs_len;

    always_comb begin
        row_done = !st_q.adj && (st_q.line >= max_line);
        last_row = (st_q.row >= v_total);
        adj_over = ((LINE_W+1)'(st_q.line) + 1'b1) >= (LINE_W+1)'(v_adjust);
        frame_wrap = st_q.adj ? adj_over
                              : (row_done && last_row && (v_adjust == '0));

        // position taken at the next line end
        nxt = st_q;
        if (frame_wrap) begin
            nxt.row  = '0;
            nxt.line = '0;
            nxt.adj  = 1'b0;
        end else if (st_q.adj) begin
            nxt.line = st_q.line + 1'b1;
        end else if (row_done) begin
            nxt.line = '0;
            if (last_row) nxt.adj = 1'b1;
            else          nxt.row = st_q.row + 1'b1;
        end else begin
            nxt.line = st_q.line + 1'b1;
        end
        next_row0 = (nxt.row == '0) && !nxt.adj;

        vs_len   = (vs_width == '0) ? VS_FULL : VS_CNT_W'(vs_width);
        vs_enter = !nxt.adj && (nxt.row == vs_pos) && (nxt.line == '0);
        if (vs_enter)
            nxt.vs_left = vs_len;
        else if (st_q.vs_left != '0)
            nxt.vs_left = st_q.vs_left - 1'b1;

        st_d = (tick && line_end) ? nxt : st_q;

        ra       = st_q.line;
        in_adj   = st_q.adj;
        v_active = !st_q.adj && (st_q.row < v_disp);
        vsync    = (st_q.vs_left != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/crt_addr_gen.sv
`timescale 1ns/1ps
module crt_addr_gen
    import crt_raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              line_end,
    input  logic              frame_wrap,
    input  logic              row_done,
    input  logic              next_row0,
    input  logic              reload_row0,
    input  logic [CHAR_W-1:0] h_disp,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] ma
);
    localparam int PAD_W = ADDR_W - CHAR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] ma;
        logic [ADDR_W-1:0] base;  // address of the row's first character
    } astate_t;

    astate_t st_d, st_q;
    logic [ADDR_W-1:0] next_base;

    always_comb begin
        next_base = st_q.base + {{PAD_W{1'b0}}, h_disp};
        st_d = st_q;
        if (tick) begin
            if (!line_end) begin
                st_d.ma = st_q.ma + 1'b1;
            end else if (frame_wrap || (reload_row0 && next_row0)) begin
                st_d.base = start_addr;
                st_d.ma   = start_addr;
            end else if (row_done) begin
                st_d.base = next_base;
                st_d.ma   = next_base;
            end else begin
                st_d.ma = st_q.base;
            end
        end
        ma = st_q.ma;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/crt_raster_timer.sv
`timescale 1ns/1ps
module crt_raster_timer
    import crt_raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              char_en,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              reload_row0,
    output logic              hsync,
    output logic              vsync,
    output logic              dispen,
    output logic [ADDR_W-1:0] ma,
    output logic [LINE_W-1:0] ra
);
    raster_cfg_t cfg;
    logic line_end, h_active, v_active, in_adj;
    logic frame_wrap, row_done, next_row0;

    crt_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    crt_hcount u_h (
        .clk      (clk),
        .rst      (rst),
        .tick     (char_en),
        .h_total  (cfg.h_total),
        .h_disp   (cfg.h_disp),
        .hs_pos   (cfg.hs_pos),
        .hs_width (cfg.hs_width),
        .line_end (line_end),
        .h_active (h_active),
        .hsync    (hsync)
    );

    crt_vcount u_v (
        .clk        (clk),
        .rst        (rst),
        .tick       (char_en),
        .line_end   (line_end),
        .v_total    (cfg.v_total),
        .v_disp     (cfg.v_disp),
        .vs_pos     (cfg.vs_pos),
        .v_adjust   (cfg.v_adjust),
        .max_line   (cfg.max_line),
        .vs_width   (cfg.vs_width),
        .ra         (ra),
        .in_adj     (in_adj),
        .v_active   (v_active),
        .vsync      (vsync),
        .frame_wrap (frame_wrap),
        .row_done   (row_done),
        .next_row0  (next_row0)
    );

    crt_addr_gen u_a (
        .clk         (clk),
        .rst         (rst),
        .tick        (char_en),
        .line_end    (line_end),
        .frame_wrap  (frame_wrap),
        .row_done    (row_done),
        .next_row0   (next_row0),
        .reload_row0 (reload_row0),
        .h_disp      (cfg.h_disp),
        .start_addr  (cfg.start_addr),
        .ma          (ma)
    );

    assign dispen = h_active && v_active;
endmodule

// File: rtl/crt_raster_sva.sv
`timescale 1ns/1ps
module crt_raster_sva
    import crt_raster_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              char_en,
    input logic              cfg_we,
    input logic              hsync,
    input logic              vsync,
    input logic              dispen,
    input logic [ADDR_W-1:0] ma,
    input logic [LINE_W-1:0] ra,
    input logic              line_end,
    input logic              frame_wrap,
    input logic              in_adj,
    input logic [ADDR_W-1:0] start_addr
);
    logic rst_q = 1'b0;

    // R1: first cycle out of reset shows the cleared state
    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q && !rst) begin
            a_r1_reset_state: assert (ma == '0 && ra == '0 && !hsync && !vsync && !dispen)
                else $error("R1 reset state wrong");
        end
    end

    // R3: with no character enable and no load, every output holds
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!char_en && !cfg_we) |=> $stable({hsync, vsync, dispen, ma, ra}))
        else $error("R3 output moved without enable");

    // R4: the extra-line tail is always blanked
    a_r4_tail_blank: assert property (@(posedge clk) disable iff (rst)
        in_adj |-> !dispen)
        else $error("R4 display enabled in tail");

    // R8: inside a line the address steps by one per character
    a_r8_ma_step: assert property (@(posedge clk) disable iff (rst)
        (char_en && !line_end) |=> (ma == ADDR_W'($past(ma) + 1'b1)))
        else $error("R8 address did not step");

    // R9: a frame wrap reloads the start address
    a_r9_frame_reload: assert property (@(posedge clk) disable iff (rst)
        (char_en && line_end && frame_wrap && !cfg_we) |=> (ma == $past(start_addr)))
        else $error("R9 start address not reloaded");

    // R7: a frame wrap returns the raster line to zero
    a_r7_wrap_line_zero: assert property (@(posedge clk) disable iff (rst)
        (char_en && line_end && frame_wrap) |=> (ra == '0))
        else $error("R7 raster line not zero after wrap");
endmodule

bind crt_raster_timer crt_raster_sva u_sva (
    .clk        (clk),
    .rst        (rst),
    .char_en    (char_en),
    .cfg_we     (cfg_we),
    .hsync      (hsync),
    .vsync      (vsync),
    .dispen     (dispen),
    .ma         (ma),
    .ra         (ra),
    .line_end   (line_end),
    .frame_wrap (frame_wrap),
    .in_adj     (in_adj),
    .start_addr (cfg.start_addr)
);

// File: tb/crt_raster_timer_tb.sv
`timescale 1ns/1ps
module crt_raster_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        char_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        reload_row0 = 1'b0;
    logic        hsync, vsync, dispen;
    logic [13:0] ma;
    logic [4:0]  ra;

    always #2.5 clk = ~clk;

    crt_raster_timer u_dut (
        .clk(clk), .rst(rst), .char_en(char_en), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .reload_row0(reload_row0),
        .hsync(hsync), .vsync(vsync), .dispen(dispen), .ma(ma), .ra(ra)
    );

    typedef struct {
        bit    hs, vs, de;
        int    ma, ra;
        bit    ticked;
        string tag;
    } exp_t;

    exp_t  q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string ma_tag = "R8";

    // reference timing values and frame position
    int c_htot, c_hdisp, c_hpos, c_hw, c_vw, c_vtot, c_vadj, c_vdisp, c_vpos, c_maxl, c_start;
    int mh, mline, mrow, madj, mhs, mvs, mma, mrs;
    bit mode = 1'b0;

    // period measurement
    bit meas = 1'b0;
    int tick_no = 0, last_hs = -1, last_vs = -1, hs_period = 0, vs_period = 0;
    bit prev_hs = 1'b0, prev_vs = 1'b0;

    task automatic check_val(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        {c_htot, c_hdisp, c_hpos, c_hw, c_vw, c_vtot} = '0;
        {c_vadj, c_vdisp, c_vpos, c_maxl, c_start} = '0;
        {mh, mline, mrow, madj, mhs, mvs, mma, mrs} = '0;
    endtask

    task automatic model_tick();
        bit endl, rowdone, wrap;
        endl = (mh >= c_htot);
        if (mh == c_hpos && c_hw != 0) mhs = c_hw - 1;
        else if (mhs > 0) mhs--;
        if (endl) begin
            rowdone = !madj && (mline >= c_maxl);
            wrap = 1'b0;
            if (madj) begin
                if (mline + 1 >= c_vadj) wrap = 1'b1; else mline++;
            end else if (rowdone) begin
                if (mrow >= c_vtot) begin
                    if (c_vadj != 0) begin madj = 1; mline = 0; end
                    else wrap = 1'b1;
                end else begin mrow++; mline = 0; end
            end else mline++;
            if (wrap) begin mrow = 0; mline = 0; madj = 0; end
            if (!madj && mrow == c_vpos && mline == 0) mvs = (c_vw == 0) ? 16 : c_vw;
            else if (mvs > 0) mvs--;
            if (wrap || (mode && mrow == 0 && !madj)) begin mrs = c_start; mma = c_start; end
            else if (rowdone) begin mrs = (mrs + c_hdisp) % 16384; mma = mrs; end
            else mma = mrs;
            mh = 0;
        end else begin
            mh++;
            mma = (mma + 1) % 16384;
        end
    endtask

    function automatic exp_t exp_now(bit ticked, string tag);
        exp_t e;
        e.hs = ((mh == c_hpos) && (c_hw != 0)) || (mhs != 0);
        e.vs = (mvs != 0);
        e.de = (mh < c_hdisp) && (mrow < c_vdisp) && !madj;
        e.ma = mma;
        e.ra = mline;
        e.ticked = ticked;
        e.tag = tag;
        return e;
    endfunction

    task automatic step(bit en);
        @(negedge clk);
        char_en = en;
        cfg_we = 1'b0;
        if (en) model_tick();
        q.push_back(exp_now(en, en ? "" : "R3"));
    endtask

    task automatic wr(int sel, int data);
        @(negedge clk);
        char_en = 1'b0;
        cfg_we = 1'b1;
        cfg_sel = 4'(sel);
        cfg_wdata = 8'(data);
        case (sel)
            0: c_htot = data;
            1: c_hdisp = data;
            2: c_hpos = data;
            3: begin c_hw = data & 15; c_vw = (data >> 4) & 15; end
            4: c_vtot = data & 127;
            5: c_vadj = data & 31;
            6: c_vdisp = data & 127;
            7: c_vpos = data & 127;
            8: c_maxl = data & 31;
            9: c_start = (c_start & 255) | ((data & 63) << 8);
            10: c_start = (c_start & 16128) | (data & 255);
            default: ;
        endcase
        q.push_back(exp_now(1'b0, "R2"));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; char_en = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
        q.push_back(exp_now(1'b0, "R1"));
    endtask

    // monitor: pops one expectation per pushed cycle, after the edge
    always begin
        exp_t e;
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            check_val(e.tag != "" ? e.tag : "R5", "hsync", hsync, e.hs);
            check_val(e.tag != "" ? e.tag : "R6", "vsync", vsync, e.vs);
            check_val(e.tag != "" ? e.tag : "R4", "dispen", dispen, e.de);
            check_val(e.tag != "" ? e.tag : ma_tag, "ma", ma, e.ma);
            check_val(e.tag != "" ? e.tag : "R7", "ra", ra, e.ra);
            if (e.ticked) begin
                tick_no++;
                if (meas && hsync && !prev_hs) begin
                    if (last_hs >= 0) hs_period = tick_no - last_hs;
                    last_hs = tick_no;
                end
                if (meas && vsync && !prev_vs) begin
                    if (last_vs >= 0) vs_period = tick_no - last_vs;
                    last_vs = tick_no;
                end
                prev_hs = hsync;
                prev_vs = vsync;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 195000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1 reset, then R7/R8/R5/R6 on a small frame with a tail
        do_reset();
        ma_tag = "R8";
        wr(0, 9); wr(1, 6); wr(2, 7); wr(3, 8'h52); wr(4, 4); wr(5, 2);
        wr(6, 3); wr(7, 3); wr(8, 2); wr(9, 8'hFF); wr(10, 8'h05);
        for (int i = 0; i < 300; i++) step(1'b1);
        // R2: unused indices leave every output untouched
        for (int s = 11; s < 16; s++) wr(s, 8'hFF);
        for (int i = 0; i < 260; i++) step(1'b1);

        // R10 with R3 gaps, no HSYNC (width 0), 16-line VSYNC
        do_reset();
        ma_tag = "R10";
        mode = 1'b1;
        reload_row0 = 1'b1;
        wr(0, 11); wr(1, 8); wr(2, 0); wr(3, 8'h00); wr(4, 3); wr(5, 0);
        wr(6, 2); wr(7, 1); wr(8, 3); wr(9, 8'h01); wr(10, 8'h23);
        for (int i = 0; i < 900; i++) step((i % 3) != 2);
        mode = 1'b0;
        reload_row0 = 1'b0;

        // R5: HSYNC wrapping over the line end, tail-only frame end
        do_reset();
        ma_tag = "R9";
        wr(0, 5); wr(1, 5); wr(2, 5); wr(3, 8'h13); wr(4, 1); wr(5, 3);
        wr(6, 5); wr(7, 0); wr(8, 0); wr(9, 8'h2A); wr(10, 8'hF0);
        for (int i = 0; i < 120; i++) step(1'b1);

        // R11 standard timing
        do_reset();
        ma_tag = "R9";
        wr(0, 63); wr(1, 40); wr(2, 46); wr(3, 8'h8E); wr(4, 38); wr(5, 0);
        wr(6, 25); wr(7, 30); wr(8, 7); wr(9, 8'h30); wr(10, 8'h00);
        meas = 1'b1;
        for (int i = 0; i < 36500; i++) step(1'b1);
        @(negedge clk);
        @(negedge clk);
        meas = 1'b0;
        check_val("R11", "hsync period", hs_period, 64);
        check_val("R11", "vsync period", vs_period, 19968);
        finish_run();
    end
endmodule